// File: doc/BRIEF.md
# Transfer Timeout and Peripheral Reset Sequencer

This block guards each handshake transfer of a parallel peripheral port against a stalled peripheral. A transfer request from the handshake logic raises the control strobe `pctl` and opens a timing window. The window closes once the port is ready again, and the meaning of ready depends on the handshake mode. In pulse mode the port is ready as soon as the strobe has dropped. In full mode the strobe must have dropped and the peripheral flag input must also report ready.

If the window stays open for the number of clock cycles the host has programmed, the block forces the port into a known state. It sets a sticky timeout flag and runs a reset sequence: the strobe is driven high for one cycle and then low, while the active-low peripheral reset line `preset_n` is held low for a time of at least the minimum pulse width. A host reset command runs the same sequence without touching the flag. Power-up and the chip reset also pulse `preset_n`. The minimum width in cycles is computed from a clock-frequency parameter.

All pins are plain control and status levels or single-cycle pulses. There is no streaming data path, so no valid/ready interface exists and no back-pressure applies.

Top module: `xfer_guard_top`

## Requirements
- R1: While `rst_n` is low, `preset_n` and `pctl` are low, `tmo_flag` is 0 and `if_ready` is 0. Counting from the cycle in which `rst_n` is released, `preset_n` stays low for exactly PRE_CYC cycles, and then `if_ready` becomes 1.
- R2: PRE_CYC is CLK_HZ × PULSE_NS / 10^9, rounded up to a whole cycle. With CLK_HZ = 1,100,000 and PULSE_NS = 15,000 this gives 17.
- R3: A `pctl_set_req` pulse while the block is idle raises `pctl` at the next clock edge, drops `if_ready`, and starts the timeout window.
- R4: In pulse mode (`full_mode` = 0), a `pctl_clr_req` pulse drops `pctl` at the next edge. The window then ends at the following edge and `if_ready` returns to 1, whatever the value of `pflg_rdy`.
- R5: In full mode (`full_mode` = 1), the window ends only when `pctl` is low and `pflg_rdy` is 1. While `pflg_rdy` stays 0, the window stays open and can expire.
- R6: If the window is still open `tmo_limit` clock edges after the edge that raised `pctl`, then at that edge `tmo_flag` becomes 1 and the reset sequence begins.
- R7: A `tmo_limit` of 0 disables expiry, so a stalled transfer then stays open indefinitely.
- R8: The reset sequence drives `pctl` high for exactly one cycle and then low. `preset_n` is low during that cycle and during the following PRE_CYC cycles, which is PRE_CYC+1 cycles in all. `seq_busy` is 1 throughout the sequence, and `if_ready` is 1 afterwards.
- R9: A `host_reset` pulse while idle or during a transfer runs the same sequence as R8 and leaves `tmo_flag` unchanged. A `host_reset` pulse while a sequence is active is ignored, so the pulse length does not change.
- R10: `tmo_flag` stays at 1 until a `tmo_clr` pulse clears it.
- R11: A `pctl_set_req` that arrives while a reset sequence is active is ignored. `pctl` stays low and the block is idle when the sequence ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip / power-up reset |
| full_mode | input | 1 | 1 = full handshake, 0 = pulse handshake |
| pflg_rdy | input | 1 | Peripheral flag in ready state (polarity already resolved) |
| pctl_set_req | input | 1 | Pulse from handshake logic: start a transfer |
| pctl_clr_req | input | 1 | Pulse from handshake logic: drop the control strobe |
| host_reset | input | 1 | Pulse: host-commanded interface reset |
| tmo_limit | input | LIM_W | Timeout window in clock cycles, 0 = disabled |
| tmo_clr | input | 1 | Pulse: clear the sticky timeout flag |
| pctl | output | 1 | Peripheral control strobe |
| preset_n | output | 1 | Active-low peripheral reset |
| tmo_flag | output | 1 | Sticky timeout status |
| seq_busy | output | 1 | Reset sequence in progress |
| if_ready | output | 1 | Interface idle and ready for a transfer |

## Verification
The assertions check the following on every cycle:
- the strobe can rise only from the idle state;
- an expiry always sets the flag and enters the sequence;
- the one-cycle strobe pulse and the minimum hold of `preset_n`;
- a ready port always closes the window;
- a zero limit never expires;
- the flag stays set until it is cleared;
- the window counter advances by one per cycle.

Only the bench scenarios can show the exact numbers:
- the pulse widths against the rounded-up cycle count;
- the expiry edge for a given limit;
- the difference between pulse-mode and full-mode ending conditions;
- that requests and host resets issued during a sequence leave no trace at the pins.

// File: rtl/xfer_guard_pkg.sv
package xfer_guard_pkg;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_ACT  = 2'd1,
    GS_SET  = 2'd2,
    GS_HOLD = 2'd3
  } guard_state_e;

  // Whole cycles needed to cover ns nanoseconds at hz, rounded up.
  function automatic longint ns_to_cycles(input longint hz, input longint ns);
    return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/xfer_window_timer.sv
module xfer_window_timer #(
  parameter int LIM_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LIM_W-1:0] limit,
  output logic             expire
);

  localparam logic [LIM_W-1:0] CNT_MAX = {LIM_W{1'b1}};

  logic [LIM_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expire = run && (limit != '0) && (cnt == limit - 1'b1);

  AST_WIN_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(cnt) != CNT_MAX) |-> (cnt == $past(cnt) + 1'b1)); // R6

endmodule

// File: rtl/preset_pulse_timer.sv
module preset_pulse_timer #(
  parameter int CYC = 750,
  parameter int W   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == W'(CYC - 1));

  AST_HOLD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= W'(CYC - 1))); // R8

endmodule

// File: rtl/xfer_guard_top.sv
module xfer_guard_top
  import xfer_guard_pkg::*;
#(
  parameter longint CLK_HZ   = 50_000_000,
  parameter longint PULSE_NS = 15_000,
  parameter int     LIM_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_mode,
  input  logic             pflg_rdy,
  input  logic             pctl_set_req,
  input  logic             pctl_clr_req,
  input  logic             host_reset,
  input  logic [LIM_W-1:0] tmo_limit,
  input  logic             tmo_clr,
  output logic             pctl,
  output logic             preset_n,
  output logic             tmo_flag,
  output logic             seq_busy,
  output logic             if_ready
);

  localparam int PRE_RAW = int'(ns_to_cycles(CLK_HZ, PULSE_NS));
  localparam int PRE_CYC = (PRE_RAW < 2) ? 2 : PRE_RAW;
  localparam int PRE_W   = $clog2(PRE_CYC + 1);

  guard_state_e st, st_nxt;
  logic pctl_q, rdy, win_exp, hold_done;

  assign rdy = !pctl_q && (!full_mode || pflg_rdy);

  xfer_window_timer #(.LIM_W(LIM_W)) i_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st == GS_ACT),
    .limit  (tmo_limit),
    .expire (win_exp)
  );

  preset_pulse_timer #(.CYC(PRE_CYC), .W(PRE_W)) i_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st == GS_HOLD),
    .done  (hold_done)
  );

  always_comb begin
    st_nxt = st;
    unique case (st)
      GS_IDLE: begin
        if (host_reset)        st_nxt = GS_SET;
        else if (pctl_set_req) st_nxt = GS_ACT;
      end
      GS_ACT: begin
        if (host_reset)   st_nxt = GS_SET;
        else if (rdy)     st_nxt = GS_IDLE;
        else if (win_exp) st_nxt = GS_SET;
      end
      GS_SET:  st_nxt = GS_HOLD;
      GS_HOLD: if (hold_done) st_nxt = GS_IDLE;
      default: st_nxt = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= GS_HOLD;
    else        st <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  pctl_q <= 1'b0;
    else if (st == GS_IDLE && st_nxt == GS_ACT)  pctl_q <= 1'b1;
    else if (st_nxt != GS_ACT)                   pctl_q <= 1'b0;
    else if (pctl_clr_req)                       pctl_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                              tmo_flag <= 1'b0;
    else if (st == GS_ACT && st_nxt == GS_SET && !host_reset) tmo_flag <= 1'b1;
    else if (tmo_clr)                                        tmo_flag <= 1'b0;
  end

  assign pctl     = pctl_q || (st == GS_SET);
  assign seq_busy = (st == GS_SET) || (st == GS_HOLD);
  assign preset_n = !seq_busy;
  assign if_ready = (st == GS_IDLE);

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pctl_q) |-> ($past(st) == GS_IDLE)); // R11
  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_ACT && win_exp && !rdy && !host_reset) |=> (tmo_flag && st == GS_SET)); // R6
  AST_SET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_SET) |=> (st == GS_HOLD && !pctl)); // R8
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_HOLD && !hold_done) |=> (!preset_n)); // R8
  AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_ACT && rdy && !host_reset) |=> (st == GS_IDLE)); // R4
  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_ACT && tmo_limit == '0 && !rdy && !host_reset) |=> (st == GS_ACT)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag); // R10

endmodule

// File: tb/test_xfer_guard_top.sv
module test_xfer_guard_top;

  localparam int CLK_PERIOD = 10;
  localparam int LIM_W      = 8;
  localparam int EXP_PRE    = 17;  // ceil(1.1e6 * 15e3 / 1e9) = ceil(16.5), R2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_mode = 1'b0, pflg_rdy = 1'b0, pctl_set_req = 1'b0, pctl_clr_req = 1'b0;
  logic host_reset = 1'b0, tmo_clr = 1'b0;
  logic [LIM_W-1:0] tmo_limit = '0;
  logic pctl, preset_n, tmo_flag, seq_busy, if_ready;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_guard_top #(.CLK_HZ(1_100_000), .PULSE_NS(15_000), .LIM_W(LIM_W)) i_xfer_guard_top (
    .clk(clk), .rst_n(rst_n), .full_mode(full_mode), .pflg_rdy(pflg_rdy),
    .pctl_set_req(pctl_set_req), .pctl_clr_req(pctl_clr_req), .host_reset(host_reset),
    .tmo_limit(tmo_limit), .tmo_clr(tmo_clr), .pctl(pctl), .preset_n(preset_n),
    .tmo_flag(tmo_flag), .seq_busy(seq_busy), .if_ready(if_ready)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Counts negedge samples with preset_n low, starting at the current one.
  task automatic count_low(output int n);
    n = 0;
    while (preset_n == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic start_xfer();
    pctl_set_req = 1'b1;
    @(negedge clk);
    pctl_set_req = 1'b0;
  endtask

  task automatic drop_pctl();
    pctl_clr_req = 1'b1;
    @(negedge clk);
    pctl_clr_req = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(preset_n, 0, "R1 preset_n in reset");
    chk(pctl, 0, "R1 pctl in reset");
    chk(tmo_flag, 0, "R1 flag in reset");
    chk(if_ready, 0, "R1 ready in reset");
    rst_n = 1'b1;
    count_low(n);
    chk(n, EXP_PRE, "R1 R2 power-up pulse cycles");
    chk(if_ready, 1, "R1 ready after pulse");
  endtask

  task automatic t_pulse_ok();
    full_mode = 1'b0; pflg_rdy = 1'b0; tmo_limit = 8'd10;
    start_xfer();
    chk(pctl, 1, "R3 pctl raised");
    chk(if_ready, 0, "R3 not ready during transfer");
    repeat (3) @(negedge clk);
    drop_pctl();
    chk(pctl, 0, "R4 pctl dropped");
    @(negedge clk);
    chk(if_ready, 1, "R4 pulse mode ready without flag");
    repeat (15) @(negedge clk);
    chk(tmo_flag, 0, "R4 no timeout after completed transfer");
    chk(preset_n, 1, "R4 no reset pulse");
  endtask

  task automatic t_full_ok();
    full_mode = 1'b1; pflg_rdy = 1'b0; tmo_limit = 8'd20;
    start_xfer();
    @(negedge clk);
    drop_pctl();
    repeat (2) @(negedge clk);
    chk(if_ready, 0, "R5 full mode waits for flag");
    pflg_rdy = 1'b1;
    @(negedge clk);
    chk(if_ready, 1, "R5 full mode ready with flag");
    chk(tmo_flag, 0, "R5 no timeout");
    pflg_rdy = 1'b0;
  endtask

  task automatic t_timeout_pulse();
    int n;
    full_mode = 1'b0; tmo_limit = 8'd5;
    start_xfer();
    repeat (4) @(negedge clk);
    chk(preset_n, 1, "R6 not expired one edge early");
    chk(tmo_flag, 0, "R6 flag clear before expiry");
    @(negedge clk);
    chk(preset_n, 0, "R6 expired at limit");
    chk(pctl, 1, "R8 pctl high first cycle of sequence");
    chk(tmo_flag, 1, "R6 flag set");
    chk(seq_busy, 1, "R8 busy in sequence");
    @(negedge clk);
    chk(pctl, 0, "R8 pctl low second cycle");
    count_low(n);
    chk(n + 1, EXP_PRE + 1, "R8 sequence pulse cycles");
    chk(if_ready, 1, "R8 ready after sequence");
    repeat (5) @(negedge clk);
    chk(tmo_flag, 1, "R10 flag sticky");
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
    chk(tmo_flag, 0, "R10 flag cleared");
  endtask

  task automatic t_timeout_full();
    int n;
    full_mode = 1'b1; pflg_rdy = 1'b0; tmo_limit = 8'd6;
    start_xfer();
    drop_pctl();
    repeat (4) @(negedge clk);
    chk(preset_n, 1, "R5 still waiting on flag");
    @(negedge clk);
    chk(tmo_flag, 1, "R5 full mode expires with flag stuck");
    count_low(n);
    chk(n, EXP_PRE + 1, "R8 pulse after full-mode expiry");
    tmo_clr = 1'b1;
    @(negedge clk);
    tmo_clr = 1'b0;
  endtask

  task automatic t_zero_limit();
    full_mode = 1'b0; tmo_limit = '0;
    start_xfer();
    repeat (300) @(negedge clk);
    chk(preset_n, 1, "R7 zero limit never expires");
    chk(pctl, 1, "R7 transfer still open");
    chk(tmo_flag, 0, "R7 no flag");
    drop_pctl();
    @(negedge clk);
    chk(if_ready, 1, "R7 transfer closes normally");
  endtask

  task automatic t_host_reset();
    int n;
    tmo_limit = 8'd10;
    host_reset = 1'b1;
    @(negedge clk);
    host_reset = 1'b0;
    chk(pctl, 1, "R9 host reset pctl high");
    chk(preset_n, 0, "R9 host reset preset low");
    chk(tmo_flag, 0, "R9 host reset leaves flag");
    n = 1;
    @(negedge clk);
    // inject a host reset and a transfer request mid-sequence
    repeat (3) begin n++; @(negedge clk); end
    host_reset = 1'b1; pctl_set_req = 1'b1;
    n++; @(negedge clk);
    host_reset = 1'b0;
    repeat (4) begin n++; @(negedge clk); end
    pctl_set_req = 1'b0;
    chk(pctl, 0, "R11 request ignored in sequence");
    while (preset_n == 1'b0 && n < 1000) begin n++; @(negedge clk); end
    chk(n, EXP_PRE + 1, "R9 host reset pulse length unchanged");
    chk(pctl, 0, "R11 pctl low after sequence");
    chk(if_ready, 1, "R11 idle after sequence");
    // host reset during a transfer
    start_xfer();
    host_reset = 1'b1;
    @(negedge clk);
    host_reset = 1'b0;
    chk(preset_n, 0, "R9 host reset during transfer");
    chk(tmo_flag, 0, "R9 flag untouched during transfer reset");
    count_low(n);
    chk(if_ready, 1, "R9 ready after transfer reset");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pulse_ok();
    t_full_ok();
    t_timeout_pulse();
    t_timeout_full();
    t_zero_limit();
    t_host_reset();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule